// File: doc/BRIEF.md
# Set-Associative TLB Command Engine

This block holds the main translation lookaside buffer of a processor's memory management unit and exposes it to software through four registers: an entry-tag word, an entry-payload word, a location word and a command word. Software stages a virtual page and address-space identifier in the tag word, then issues commands. Probe looks the page up. Get-location picks a slot for it. Two write flavours commit the staged words, and they differ only in whether the small per-pipeline translation caches (micro-TLBs) must be flushed. Read copies an entry back into the staged words. A last command flushes the micro-TLBs on its own.

The array is organised as a parameterised number of sets (128 by default) by 2 or 4 ways. An entry's linear location is `set * WAYS + way`, so the ways of one set sit at consecutive locations. The set is chosen by the virtual page bits just above the page offset. The block does not check for duplicates when an entry is installed. It detects them at lookup time and reports them in the location word. Every command takes a fixed number of cycles, during which the block reports busy.

Top module: `tlbe_engine`

## Requirements
- R1: Tag word layout: bits [7:0] hold the 8-bit ASID, bit 8 holds the valid flag, and bits [31:PAGE_BITS] hold the virtual page number (PAGE_BITS=12 by default). The set is the page number's low log2(SETS) bits. The location of way w in set s is s*WAYS+w, held in the low bits of the location word.
- R2: Probe (command code 1) compares the tag word's page number and ASID with every valid way of the selected set. Exactly one match loads the location word with that way's location and clears both flag bits.
- R3: A probe with no match loads the location word with 0x8000_0000 (lookup-error flag bit 31 set, location zero).
- R4: A probe that matches two or more ways loads the location word with 0xC000_0000 (bit 31 and duplicate flag bit 30 both set).
- R5: Get-location (code 2) picks the lowest-numbered invalid way of the selected set. If every way is valid, it picks that set's round-robin victim, which starts at way 0 after reset and advances by one each time it is used. The location word is loaded with the pick and both flags are cleared.
- R6: Write (code 3) stores the tag and payload words at the location in the location word. It also drives `utlb_inval` high for exactly one cycle, in the cycle where busy falls.
- R7: Write-keep (code 4) stores the entry exactly like write but never raises `utlb_inval`.
- R8: Micro-flush (code 6) raises `utlb_inval` for one cycle and leaves the array and all registers unchanged.
- R9: Read (code 5) loads the tag and payload words from the entry at the location word.
- R10: Writing an all-zero tag and payload to a location erases it, so later probes no longer match it.
- R11: An accepted command holds `busy` high for CMD_LAT cycles (2 by default). Register writes and commands issued while busy are ignored. Command codes 0 and 7 (taken from write data bits [2:0]) are ignored and do not raise busy.
- R12: While the location word's bit 31 is set, write, write-keep and read change nothing and raise no `utlb_inval`.
- R13: After reset, all registers read zero, busy and `utlb_inval` are low, every entry is invalid, and every round-robin victim is way 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 tag, 1 payload, 2 location, 3 command |
| reg_wdata | input | 32 | Register write data |
| pd0_q | output | 32 | Entry-tag word |
| pd1_q | output | 32 | Entry-payload word |
| idx_q | output | 32 | Location word with error flags in bits 31 and 30 |
| busy | output | 1 | Command in progress |
| utlb_inval | output | 1 | One-cycle micro-TLB invalidate pulse |

## Verification
The bench targets the round-robin rollover on a full set, where a victim pointer that is shared across sets or never advances would return the same location twice. A duplicate match followed by a write tests the error guard, and a design that ignored the flag would overwrite entry zero of the array. Writes issued in the middle of a busy window would corrupt the staged tag if the busy guard leaked. Write-keep is compared against write to catch a flush pulse raised on the wrong flavour.

// File: rtl/tlbe_pkg.sv
package tlbe_pkg;

   localparam int unsigned WORD_W    = 32;
   localparam int unsigned ASID_W    = 8;
   localparam int unsigned VALID_BIT = 8;

   typedef enum logic [2:0] {
      OP_NONE       = 3'd0,
      OP_PROBE      = 3'd1,
      OP_GETIDX     = 3'd2,
      OP_WRITE      = 3'd3,
      OP_WRITE_KEEP = 3'd4,
      OP_READ       = 3'd5,
      OP_UFLUSH     = 3'd6,
      OP_RSVD       = 3'd7
   } tlb_op_e;

   typedef enum logic [1:0] {
      SEL_TAG  = 2'd0,
      SEL_PAY  = 2'd1,
      SEL_LOC  = 2'd2,
      SEL_CMD  = 2'd3
   } reg_sel_e;

   function automatic logic op_known(input logic [2:0] code);
      return (code != 3'd0) && (code != 3'd7);
   endfunction

endpackage

// File: rtl/tlbe_ctrl.sv
module tlbe_ctrl
   import tlbe_pkg::*;
#(
   parameter int unsigned CMD_LAT = 2
) (
   input  logic    clk,
   input  logic    rst,
   input  logic    start,
   input  tlb_op_e op_in,
   output tlb_op_e op_q,
   output logic    busy,
   output logic    exec
);

   localparam int unsigned CNT_W = $clog2(CMD_LAT + 1);

   if (CMD_LAT < 1) begin : g_bad_lat
      $error("tlbe_ctrl: CMD_LAT must be at least 1");
   end

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt  <= '0;
         op_q <= OP_NONE;
      end else if (cnt != '0) begin
         cnt <= cnt - CNT_W'(1);
      end else if (start) begin
         cnt  <= CNT_W'(CMD_LAT);
         op_q <= op_in;
      end
   end

   assign busy = (cnt != '0);
   assign exec = (cnt == CNT_W'(1));

   p_accept_busy_r11: assert property (@(posedge clk) disable iff (rst)
      start |=> busy);

   p_exec_ends_r11: assert property (@(posedge clk) disable iff (rst)
      exec |=> !busy);

endmodule

// File: rtl/tlbe_lookup.sv
module tlbe_lookup
   import tlbe_pkg::*;
#(
   parameter int unsigned WAYS      = 4,
   parameter int unsigned PAGE_BITS = 12,
   localparam int unsigned WAY_W    = $clog2(WAYS),
   localparam int unsigned HCNT_W   = $clog2(WAYS + 1)
) (
   input  logic [WAYS-1:0][WORD_W-1:0] way_tag,
   input  logic [WORD_W-1:0]           key,
   output logic [HCNT_W-1:0]           hit_cnt,
   output logic [WAY_W-1:0]            hit_way,
   output logic                        free_any,
   output logic [WAY_W-1:0]            free_way
);

   localparam logic [WORD_W-1:0] CMP_MASK =
      ({WORD_W{1'b1}} << PAGE_BITS) | WORD_W'((1 << ASID_W) - 1);

   logic [WAYS-1:0] match;
   logic [WAYS-1:0] empty;

   for (genvar w = 0; w < WAYS; w++) begin : g_way
      assign match[w] = way_tag[w][VALID_BIT] &&
                        (((way_tag[w] ^ key) & CMP_MASK) == '0);
      assign empty[w] = !way_tag[w][VALID_BIT];
   end

   always_comb begin
      hit_cnt = '0;
      hit_way = '0;
      for (int w = 0; w < WAYS; w++) begin
         if (match[w]) begin
            hit_cnt = hit_cnt + HCNT_W'(1);
            hit_way = WAY_W'(w);
         end
      end
   end

   always_comb begin
      free_way = '0;
      for (int w = WAYS - 1; w >= 0; w--) begin
         if (empty[w]) free_way = WAY_W'(w);
      end
   end

   assign free_any = |empty;

   always_comb begin
      a_hits_bounded_r4: assert ($countones(match) == int'(hit_cnt));
   end

endmodule

// File: rtl/tlbe_victim.sv
module tlbe_victim #(
   parameter int unsigned SETS = 128,
   parameter int unsigned WAYS = 4,
   localparam int unsigned SET_W = $clog2(SETS),
   localparam int unsigned WAY_W = $clog2(WAYS)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [SET_W-1:0] set_sel,
   input  logic             advance,
   output logic [WAY_W-1:0] victim
);

   logic [WAY_W-1:0] rr [SETS];

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int s = 0; s < SETS; s++) rr[s] <= '0;
      end else if (advance) begin
         rr[set_sel] <= rr[set_sel] + WAY_W'(1);
      end
   end

   assign victim = rr[set_sel];

   p_rr_step_r5: assert property (@(posedge clk) disable iff (rst)
      advance |=> (rr[$past(set_sel)] == $past(victim) + WAY_W'(1)));

endmodule

// File: rtl/tlbe_engine.sv
module tlbe_engine
   import tlbe_pkg::*;
#(
   parameter int unsigned SETS      = 128,
   parameter int unsigned WAYS      = 4,
   parameter int unsigned PAGE_BITS = 12,
   parameter int unsigned CMD_LAT   = 2
) (
   input  logic        clk,
   input  logic        rst,
   input  logic        reg_we,
   input  logic [1:0]  reg_sel,
   input  logic [31:0] reg_wdata,
   output logic [31:0] pd0_q,
   output logic [31:0] pd1_q,
   output logic [31:0] idx_q,
   output logic        busy,
   output logic        utlb_inval
);

   localparam int unsigned SET_W   = $clog2(SETS);
   localparam int unsigned WAY_W   = $clog2(WAYS);
   localparam int unsigned IDX_W   = SET_W + WAY_W;
   localparam int unsigned NUM_ENT = SETS * WAYS;
   localparam int unsigned HCNT_W  = $clog2(WAYS + 1);

   if (WAYS != 2 && WAYS != 4) begin : g_bad_ways
      $error("tlbe_engine: WAYS must be 2 or 4");
   end
   if ((SETS & (SETS - 1)) != 0 || SETS < 2) begin : g_bad_sets
      $error("tlbe_engine: SETS must be a power of two");
   end
   if (PAGE_BITS < VALID_BIT + 1 || PAGE_BITS + SET_W > WORD_W) begin : g_bad_page
      $error("tlbe_engine: PAGE_BITS leaves no room for tag fields");
   end

   // staged registers
   logic [WORD_W-1:0] tag_r, pay_r;
   logic              loc_err, loc_dup;
   logic [IDX_W-1:0]  loc_val;
   logic              inval_r;

   // entry array
   logic [WORD_W-1:0] ent_tag [NUM_ENT];
   logic [WORD_W-1:0] ent_pay [NUM_ENT];

   // control
   tlb_op_e op_q;
   logic    exec;
   logic    start;

   assign start = reg_we && (reg_sel == SEL_CMD) && !busy && op_known(reg_wdata[2:0]);

   tlbe_ctrl #(.CMD_LAT(CMD_LAT)) u_ctrl (
      .clk   (clk),
      .rst   (rst),
      .start (start),
      .op_in (tlb_op_e'(reg_wdata[2:0])),
      .op_q  (op_q),
      .busy  (busy),
      .exec  (exec)
   );

   // set selection and way gather
   logic [SET_W-1:0]                set_sel;
   logic [WAYS-1:0][WORD_W-1:0]     set_tag;

   assign set_sel = tag_r[PAGE_BITS +: SET_W];

   for (genvar w = 0; w < WAYS; w++) begin : g_gather
      assign set_tag[w] = ent_tag[{set_sel, WAY_W'(w)}];
   end

   logic [HCNT_W-1:0] hit_cnt;
   logic [WAY_W-1:0]  hit_way;
   logic              free_any;
   logic [WAY_W-1:0]  free_way;

   tlbe_lookup #(.WAYS(WAYS), .PAGE_BITS(PAGE_BITS)) u_lookup (
      .way_tag  (set_tag),
      .key      (tag_r),
      .hit_cnt  (hit_cnt),
      .hit_way  (hit_way),
      .free_any (free_any),
      .free_way (free_way)
   );

   logic [WAY_W-1:0] victim;
   logic             rr_adv;

   assign rr_adv = exec && (op_q == OP_GETIDX) && !free_any;

   tlbe_victim #(.SETS(SETS), .WAYS(WAYS)) u_victim (
      .clk     (clk),
      .rst     (rst),
      .set_sel (set_sel),
      .advance (rr_adv),
      .victim  (victim)
   );

   logic [WAY_W-1:0] pick_way;
   logic             store_en;

   assign pick_way = free_any ? free_way : victim;
   assign store_en = exec && !loc_err &&
                     ((op_q == OP_WRITE) || (op_q == OP_WRITE_KEEP));

   // register file and command results
   always_ff @(posedge clk) begin
      if (rst) begin
         tag_r   <= '0;
         pay_r   <= '0;
         loc_err <= 1'b0;
         loc_dup <= 1'b0;
         loc_val <= '0;
         inval_r <= 1'b0;
      end else begin
         inval_r <= 1'b0;
         if (exec) begin
            case (op_q)
               OP_PROBE: begin
                  if (hit_cnt == '0) begin
                     loc_err <= 1'b1;
                     loc_dup <= 1'b0;
                     loc_val <= '0;
                  end else if (hit_cnt == HCNT_W'(1)) begin
                     loc_err <= 1'b0;
                     loc_dup <= 1'b0;
                     loc_val <= {set_sel, hit_way};
                  end else begin
                     loc_err <= 1'b1;
                     loc_dup <= 1'b1;
                     loc_val <= '0;
                  end
               end
               OP_GETIDX: begin
                  loc_err <= 1'b0;
                  loc_dup <= 1'b0;
                  loc_val <= {set_sel, pick_way};
               end
               OP_WRITE: begin
                  if (!loc_err) inval_r <= 1'b1;
               end
               OP_READ: begin
                  if (!loc_err) begin
                     tag_r <= ent_tag[loc_val];
                     pay_r <= ent_pay[loc_val];
                  end
               end
               OP_UFLUSH: inval_r <= 1'b1;
               default: ;
            endcase
         end else if (reg_we && !busy) begin
            case (reg_sel)
               SEL_TAG: tag_r <= reg_wdata;
               SEL_PAY: pay_r <= reg_wdata;
               SEL_LOC: begin
                  loc_val <= reg_wdata[IDX_W-1:0];
                  loc_err <= 1'b0;
                  loc_dup <= 1'b0;
               end
               default: ;
            endcase
         end
      end
   end

   // entry storage
   always_ff @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < NUM_ENT; i++) begin
            ent_tag[i] <= '0;
            ent_pay[i] <= '0;
         end
      end else if (store_en) begin
         ent_tag[loc_val] <= tag_r;
         ent_pay[loc_val] <= pay_r;
      end
   end

   assign pd0_q      = tag_r;
   assign pd1_q      = pay_r;
   assign idx_q      = {loc_err, loc_dup, {(WORD_W - 2 - IDX_W){1'b0}}, loc_val};
   assign utlb_inval = inval_r;

   p_inval_at_finish_r6: assert property (@(posedge clk) disable iff (rst)
      utlb_inval |-> $fell(busy));

   p_inval_one_cycle_r8: assert property (@(posedge clk) disable iff (rst)
      utlb_inval |=> !utlb_inval);

   p_keep_no_flush_r7: assert property (@(posedge clk) disable iff (rst)
      (exec && op_q == OP_WRITE_KEEP) |=> !utlb_inval);

   p_busy_freeze_r11: assert property (@(posedge clk) disable iff (rst)
      (busy && !exec) |=> ($stable(pd0_q) && $stable(pd1_q) && $stable(idx_q)));

   p_getidx_clean_r5: assert property (@(posedge clk) disable iff (rst)
      (exec && op_q == OP_GETIDX) |=> (idx_q[31:30] == 2'b00));

   p_err_blocks_read_r12: assert property (@(posedge clk) disable iff (rst)
      (exec && op_q == OP_READ && idx_q[31]) |=> ($stable(pd0_q) && $stable(pd1_q)));

endmodule

// File: tb/tlbe_engine_test.sv
module tlbe_engine_test;

   localparam int W   = 4;
   localparam int LAT = 2;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        reg_we = 1'b0;
   logic [1:0]  reg_sel = 2'd0;
   logic [31:0] reg_wdata = 32'd0;
   logic [31:0] pd0_q, pd1_q, idx_q;
   logic        busy, utlb_inval;

   always #5 clk = ~clk;

   tlbe_engine uut (
      .clk(clk), .rst(rst), .reg_we(reg_we), .reg_sel(reg_sel),
      .reg_wdata(reg_wdata), .pd0_q(pd0_q), .pd1_q(pd1_q), .idx_q(idx_q),
      .busy(busy), .utlb_inval(utlb_inval)
   );

   int    n_cmp = 0;
   int    n_bad = 0;
   string cur_req = "R13";

   // ---------------- reference model ----------------
   logic [31:0] m_tag [512];
   logic [31:0] m_pay [512];
   int          m_rr  [128];
   logic [31:0] m_pd0, m_pd1, m_idx;
   int          m_cnt, m_cmd;
   logic        m_inv;

   task automatic m_exec();
      int set, hits, loc, pick;
      set = int'(m_pd0[18:12]);
      case (m_cmd)
         1: begin
            hits = 0; loc = 0;
            for (int w = 0; w < W; w++) begin
               logic [31:0] e;
               e = m_tag[set*W + w];
               if (e[8] && e[31:12] == m_pd0[31:12] && e[7:0] == m_pd0[7:0]) begin
                  hits++; loc = set*W + w;
               end
            end
            if (hits == 0) m_idx = 32'h8000_0000;
            else if (hits == 1) m_idx = 32'(loc);
            else m_idx = 32'hC000_0000;
         end
         2: begin
            pick = -1;
            for (int w = W - 1; w >= 0; w--)
               if (!m_tag[set*W + w][8]) pick = w;
            if (pick < 0) begin
               pick = m_rr[set];
               m_rr[set] = (pick + 1) % W;
            end
            m_idx = 32'(set*W + pick);
         end
         3, 4: if (!m_idx[31]) begin
            m_tag[m_idx[8:0]] = m_pd0;
            m_pay[m_idx[8:0]] = m_pd1;
            if (m_cmd == 3) m_inv = 1'b1;
         end
         5: if (!m_idx[31]) begin
            m_pd0 = m_tag[m_idx[8:0]];
            m_pd1 = m_pay[m_idx[8:0]];
         end
         6: m_inv = 1'b1;
         default: ;
      endcase
   endtask

   always @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < 512; i++) begin m_tag[i] = '0; m_pay[i] = '0; end
         for (int s = 0; s < 128; s++) m_rr[s] = 0;
         m_pd0 = '0; m_pd1 = '0; m_idx = '0; m_cnt = 0; m_cmd = 0; m_inv = 1'b0;
      end else begin
         m_inv = 1'b0;
         if (m_cnt != 0) begin
            m_cnt--;
            if (m_cnt == 0) m_exec();
         end else if (reg_we) begin
            case (reg_sel)
               2'd0: m_pd0 = reg_wdata;
               2'd1: m_pd1 = reg_wdata;
               2'd2: m_idx = reg_wdata & 32'h1FF;
               default: if (reg_wdata[2:0] != 3'd0 && reg_wdata[2:0] != 3'd7) begin
                  m_cmd = int'(reg_wdata[2:0]);
                  m_cnt = LAT;
               end
            endcase
         end
      end
   end

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // every-clock comparison against the model
   always @(negedge clk) begin
      if (!rst) begin
         chk(cur_req, "pd0_q", pd0_q, m_pd0);
         chk(cur_req, "pd1_q", pd1_q, m_pd1);
         chk(cur_req, "idx_q", idx_q, m_idx);
         chk(cur_req, "busy", 32'(busy), 32'(m_cnt != 0));
         chk(cur_req, "utlb_inval", 32'(utlb_inval), 32'(m_inv));
      end
   end

   // ---------------- stimulus helpers ----------------
   function automatic logic [31:0] mk(input int vpn, input int asid);
      return (32'(vpn) << 12) | 32'h100 | 32'(asid & 8'hFF);
   endfunction

   task automatic wr(input logic [1:0] sel, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic run(input int op);
      wr(2'd3, 32'(op));
      while (busy) @(negedge clk);
      @(negedge clk);
   endtask

   // ---------------- watchdog ----------------
   int cycles = 0;
   always @(posedge clk) begin
      cycles++;
      if (cycles > 50000) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog: actual %0d cycles expected fewer than 50000", cycles);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   // ---------------- test sequence ----------------
   initial begin
      repeat (4) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      cur_req = "R13";
      chk("R13", "reset idx", idx_q, 32'h0);
      chk("R13", "reset busy", 32'(busy), 32'h0);

      // R1 R6: write entry A at set 5 way 2
      cur_req = "R6";
      wr(2'd0, mk(5, 8'h11)); wr(2'd1, 32'hABCD_E03F); wr(2'd2, 32'd22);
      run(3);

      cur_req = "R2";
      run(1);
      chk("R2", "probe hit", idx_q, 32'd22);

      cur_req = "R3";
      wr(2'd0, mk(5, 8'h12));
      run(1);
      chk("R3", "probe miss", idx_q, 32'h8000_0000);

      cur_req = "R9";
      wr(2'd0, 32'hDEAD_0000); wr(2'd1, 32'h0); wr(2'd2, 32'd22);
      run(5);
      chk("R9", "read tag", pd0_q, 32'h0000_5111);
      chk("R9", "read pay", pd1_q, 32'hABCD_E03F);

      cur_req = "R7";
      wr(2'd0, mk(8'h85, 8'h11)); wr(2'd1, 32'h1234_5007); wr(2'd2, 32'd23);
      run(4);
      run(1);
      chk("R7", "probe after write-keep", idx_q, 32'd23);

      cur_req = "R4";
      wr(2'd0, mk(5, 8'h11)); wr(2'd1, 32'h1); wr(2'd2, 32'd20);
      run(3);
      run(1);
      chk("R4", "duplicate code", idx_q, 32'hC000_0000);

      cur_req = "R12";
      wr(2'd0, 32'h0000_0000);
      run(3);
      run(5);
      chk("R12", "read under error", pd0_q, 32'h0);
      chk("R12", "idx kept", idx_q, 32'hC000_0000);

      cur_req = "R5";
      wr(2'd0, mk(5, 8'h33));
      run(2);
      chk("R5", "free way set5", idx_q, 32'd21);
      wr(2'd0, mk(9, 1));
      run(2);
      chk("R5", "empty set9", idx_q, 32'd36);
      for (int w = 0; w < 4; w++) begin
         wr(2'd0, mk(9 + 128*w, 1)); wr(2'd2, 32'(36 + w));
         run(3);
      end
      wr(2'd0, mk(12'h209, 2));
      for (int k = 0; k < 5; k++) begin
         run(2);
         chk("R5", "round robin", idx_q, 32'(36 + (k % 4)));
      end

      cur_req = "R10";
      wr(2'd0, 32'h0); wr(2'd1, 32'h0); wr(2'd2, 32'd22);
      run(3);
      wr(2'd0, mk(5, 8'h11));
      run(1);
      chk("R10", "after erase one", idx_q, 32'd20);
      wr(2'd0, 32'h0); wr(2'd2, 32'd20);
      run(3);
      wr(2'd0, mk(5, 8'h11));
      run(1);
      chk("R10", "after erase both", idx_q, 32'h8000_0000);

      cur_req = "R8";
      run(6);

      cur_req = "R11";
      wr(2'd3, 32'd1);
      wr(2'd0, 32'hFFFF_FFFF);
      wr(2'd3, 32'd5);
      while (busy) @(negedge clk);
      @(negedge clk);
      chk("R11", "tag unchanged", pd0_q, mk(5, 8'h11));
      wr(2'd3, 32'd0);
      chk("R11", "code 0 ignored", 32'(busy), 32'h0);
      wr(2'd3, 32'd7);
      chk("R11", "code 7 ignored", 32'(busy), 32'h0);

      repeat (3) @(negedge clk);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule